// File: doc/BRIEF.md
# Regulator Startup and Fault Sequencer

This block is the control state machine of a single-phase switching regulator. It runs on the switching clock and takes flags that have already been digitized: two supply-good flags, an enable level, comparator results for overvoltage, undervoltage, a lower and a higher overcurrent level, output-below-discharge-level, and one thermal fault flag. From these it produces a reference ramp code for the error amplifier, a power-good flag, a gate-control command, an output-discharge command and a latched-fault flag.

A start is allowed only when both supplies are good and enable is high. The block then waits a fixed number of cycles and steps the reference code up by one per cycle from zero to full scale, with switching allowed. Power-good follows a short settling delay. Protection depends on the state. Overvoltage latches at once in every powered state. An undervoltage during the late part of the ramp restarts the sequence, while an undervoltage in steady regulation latches. A lower-level overcurrent is retried a fixed number of times before it latches, and a higher-level overcurrent latches at once. A latched fault clears only when enable goes low or a supply drops.

All pins are plain levels. No data stream crosses the boundary, so there is no handshake.

Top module: `psu_seq_top`

## Requirements
- R1: While `supply_ok_a`, `supply_ok_b` and `enable` are not all high, no start occurs and `gate_mode` never reads 01. Gate encodings: 00 = both gates off, 01 = switching allowed, 10 = top gate off and bottom gate on.
- R2: When all three start inputs are high in idle, the gates stay off for WAIT_CYC cycles. Then `ref_code` counts 0,1,…,1023, one step per clock, with `gate_mode` = 01. It holds at 1023 afterwards.
- R3: `pgood` rises 3 cycles after `ref_code` reaches 1023, which is 1 + WAIT_CYC + 1024 + 3 cycles after the start condition. It is high only in regulation while both `uv_flag` and `ov_flag` are low, and the drop on a window violation is combinational.
- R4: `ov_flag` in any waiting, ramping or regulating state sets `fault_latched`, drives `gate_mode` = 10 and forces `pgood` low on the next clock.
- R5: `uv_flag` has no effect while `ref_code` is below 818, which is 80% of full scale.
- R6: `uv_flag` after that point during soft-start turns the gates off without latching and restarts the full wait-and-ramp sequence. In regulation, `uv_flag` latches a fault.
- R7: `oc_lo_flag` while switching turns the gates off and restarts soft-start. The fifth occurrence, after four restarts, latches a fault. The retry count clears when regulation is reached or the block returns to idle.
- R8: `oc_hi_flag` while switching latches a fault with both gates off on the next clock, with no retry.
- R9: After a latched non-overvoltage fault or a normal disable, `discharge` is high while `below_dis_flag` is low. A disabled sequencer returns to idle once `below_dis_flag` is high.
- R10: In idle or disable-discharge, `ov_flag` drives `gate_mode` = 10 without setting `fault_latched`.
- R11: A latched fault holds while the start condition holds. It clears to idle when the start condition goes low.
- R12: `therm_flag` in a powered state latches a fault with both gates off and discharge, as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_a | input | 1 | Controller supply good |
| supply_ok_b | input | 1 | Driver supply good |
| enable | input | 1 | Enable level, high to run |
| ov_flag | input | 1 | Output above 125% of reference |
| uv_flag | input | 1 | Output below 75% of reference |
| oc_lo_flag | input | 1 | Current above the lower limit |
| oc_hi_flag | input | 1 | Current above the upper limit |
| therm_flag | input | 1 | Thermal fault |
| below_dis_flag | input | 1 | Output below 50% of reference |
| ref_code | output | RAMP_W | Reference ramp code |
| pgood | output | 1 | Power good |
| gate_mode | output | 2 | Gate command (00 off, 01 switch, 10 bottom on) |
| discharge | output | 1 | Output discharge command |
| fault_latched | output | 1 | A fault is latched |

## Verification
The ramp is tried on a clean start, and the exact count of cycles to power-good separates a correct wait length from an off-by-one in the wait, the ramp or the settling delay. Undervoltage pulses are applied once below and once above the 80% point of the ramp, and once in regulation. This tells the ignored, restarting and latching behaviours apart. Trains of lower-level overcurrent pulses check the re-entry count against the one-shot upper level. Overvoltage is applied both in idle and during the ramp to separate the pre-monitor from the latching response. A behavioural model is compared with every output on every clock.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_RAMP = 3'd2,
    S_PGD  = 3'd3,
    S_RUN  = 3'd4,
    S_FOV  = 3'd5,
    S_FOFF = 3'd6,
    S_DIS  = 3'd7
  } seq_st_t;

  typedef enum logic [1:0] {
    G_OFF = 2'b00,
    G_PWM = 2'b01,
    G_LOW = 2'b10
  } gate_t;
endpackage

// File: rtl/psu_seq_timer.sv
module psu_seq_timer
  import psu_seq_pkg::*;
#(
  parameter int WAIT_CYC = 64,
  parameter int RAMP_W   = 10,
  parameter int PG_DLY   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_t           st,
  input  seq_st_t           st_nxt,
  output logic              wait_done,
  output logic              ramp_done,
  output logic              pgd_done,
  output logic              uv_armed,
  output logic [RAMP_W-1:0] ref_code
);
  localparam int FULL   = (1 << RAMP_W) - 1;
  localparam int UV_ARM = (FULL * 4) / 5;
  localparam int WB     = $clog2(WAIT_CYC + 1);
  localparam int PB     = $clog2(PG_DLY + 1);
  localparam int CW0    = (WB > RAMP_W) ? WB : RAMP_W;
  localparam int CW     = (PB > CW0) ? PB : CW0;

  logic [CW-1:0] cnt;
  logic          counting;

  assign counting = (st == S_WAIT) || (st == S_RAMP) || (st == S_PGD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (st_nxt != st)   cnt <= '0;
    else if (counting)       cnt <= cnt + 1'b1;
  end

  assign wait_done = (st == S_WAIT) && (cnt == CW'(WAIT_CYC - 1));
  assign ramp_done = (st == S_RAMP) && (cnt == CW'(FULL));
  assign pgd_done  = (st == S_PGD)  && (cnt == CW'(PG_DLY - 1));
  assign uv_armed  = ((st == S_RAMP) && (cnt >= CW'(UV_ARM))) ||
                     (st == S_PGD) || (st == S_RUN);

  always_comb begin
    if (st == S_RAMP)                       ref_code = cnt[RAMP_W-1:0];
    else if ((st == S_PGD) || (st == S_RUN)) ref_code = '1;
    else                                    ref_code = '0;
  end

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && st_nxt == S_RAMP) |=> (ref_code == $past(ref_code) + 1'b1)); // R2
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (cnt < CW'(WAIT_CYC))); // R2
endmodule

// File: rtl/psu_seq_retry.sv
module psu_seq_retry #(
  parameter int OC_RETRY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clr,
  output logic exhausted
);
  localparam int RB = $clog2(OC_RETRY + 1);

  logic [RB-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == RB'(OC_RETRY));

  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RB'(OC_RETRY)); // R7
  AST_RETRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/psu_seq_fsm.sv
module psu_seq_fsm
  import psu_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  input  logic    ov,
  input  logic    uv,
  input  logic    oc_lo,
  input  logic    oc_hi,
  input  logic    therm,
  input  logic    below_dis,
  input  logic    wait_done,
  input  logic    ramp_done,
  input  logic    pgd_done,
  input  logic    uv_armed,
  input  logic    retry_exh,
  output seq_st_t st,
  output seq_st_t st_nxt,
  output logic    retry_bump,
  output logic    retry_clr
);
  logic switching;

  assign switching = (st == S_RAMP) || (st == S_PGD) || (st == S_RUN);

  always_comb begin
    st_nxt     = st;
    retry_bump = 1'b0;
    retry_clr  = 1'b0;
    unique case (st)
      S_IDLE: begin
        retry_clr = 1'b1;
        if (go) st_nxt = S_WAIT;
      end
      S_WAIT, S_RAMP, S_PGD, S_RUN: begin
        if (ov)                       st_nxt = S_FOV;
        else if (therm)               st_nxt = S_FOFF;
        else if (!go)                 st_nxt = S_DIS;
        else if (switching && oc_hi)  st_nxt = S_FOFF;
        else if (switching && oc_lo) begin
          if (retry_exh) st_nxt = S_FOFF;
          else begin
            st_nxt     = S_WAIT;
            retry_bump = 1'b1;
          end
        end
        else if (uv_armed && uv)      st_nxt = (st == S_RUN) ? S_FOFF : S_WAIT;
        else if (wait_done)           st_nxt = S_RAMP;
        else if (ramp_done)           st_nxt = S_PGD;
        else if (pgd_done) begin
          st_nxt    = S_RUN;
          retry_clr = 1'b1;
        end
      end
      S_FOV:  if (!go) st_nxt = S_IDLE;
      S_FOFF: begin
        if (ov)       st_nxt = S_FOV;
        else if (!go) st_nxt = S_IDLE;
      end
      S_DIS:  if (below_dis) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nxt;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FOFF && go && !ov) |=> (st == S_FOFF)); // R11
  AST_UV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && !uv_armed && !ov && !therm && go && !oc_lo && !oc_hi && !wait_done && !ramp_done)
      |=> (st == S_RAMP)); // R5
endmodule

// File: rtl/psu_seq_top.sv
module psu_seq_top
  import psu_seq_pkg::*;
#(
  parameter int WAIT_CYC = 64,
  parameter int RAMP_W   = 10,
  parameter int PG_DLY   = 3,
  parameter int OC_RETRY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok_a,
  input  logic              supply_ok_b,
  input  logic              enable,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic              oc_lo_flag,
  input  logic              oc_hi_flag,
  input  logic              therm_flag,
  input  logic              below_dis_flag,
  output logic [RAMP_W-1:0] ref_code,
  output logic              pgood,
  output logic [1:0]        gate_mode,
  output logic              discharge,
  output logic              fault_latched
);
  seq_st_t st, st_nxt;
  logic    go;
  logic    wait_done, ramp_done, pgd_done, uv_armed;
  logic    retry_bump, retry_clr, retry_exh;
  gate_t   gate_c;

  assign go = supply_ok_a && supply_ok_b && enable;

  psu_seq_timer #(.WAIT_CYC(WAIT_CYC), .RAMP_W(RAMP_W), .PG_DLY(PG_DLY)) u_timer (
    .clk(clk), .rst_n(rst_n), .st(st), .st_nxt(st_nxt),
    .wait_done(wait_done), .ramp_done(ramp_done), .pgd_done(pgd_done),
    .uv_armed(uv_armed), .ref_code(ref_code)
  );

  psu_seq_retry #(.OC_RETRY(OC_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .bump(retry_bump), .clr(retry_clr),
    .exhausted(retry_exh)
  );

  psu_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .ov(ov_flag), .uv(uv_flag),
    .oc_lo(oc_lo_flag), .oc_hi(oc_hi_flag), .therm(therm_flag),
    .below_dis(below_dis_flag), .wait_done(wait_done), .ramp_done(ramp_done),
    .pgd_done(pgd_done), .uv_armed(uv_armed), .retry_exh(retry_exh),
    .st(st), .st_nxt(st_nxt), .retry_bump(retry_bump), .retry_clr(retry_clr)
  );

  always_comb begin
    unique case (st)
      S_RAMP, S_PGD, S_RUN: gate_c = G_PWM;
      S_FOV:                gate_c = G_LOW;
      S_IDLE, S_DIS:        gate_c = ov_flag ? G_LOW : G_OFF;
      default:              gate_c = G_OFF;
    endcase
  end

  assign gate_mode     = gate_c;
  assign pgood         = (st == S_RUN) && !uv_flag && !ov_flag;
  assign discharge     = ((st == S_FOFF) || (st == S_DIS)) && !below_dis_flag;
  assign fault_latched = (st == S_FOV) || (st == S_FOFF);

  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!go) |=> (gate_mode != G_PWM)); // R1
  AST_OV_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && gate_mode == G_PWM) |=> (fault_latched && gate_mode == G_LOW && !pgood)); // R4
  AST_OC_HI_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hi_flag && gate_mode == G_PWM) |=> (gate_mode != G_PWM)); // R8
  AST_PG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (ref_code == '1)); // R3
  AST_DIS_NOSW: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |-> (gate_mode != G_PWM)); // R9
endmodule

// File: tb/psu_seq_top_bench.sv
module psu_seq_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa = 0, sb = 0, en = 0, ov = 0, uv = 0, ocl = 0, och = 0, th = 0, bd = 0;
  logic [9:0] ref_code;
  logic       pgood, discharge, fault_latched;
  logic [1:0] gate_mode;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psu_seq_top u_psu_seq_top (
    .clk(clk), .rst_n(rst_n), .supply_ok_a(sa), .supply_ok_b(sb), .enable(en),
    .ov_flag(ov), .uv_flag(uv), .oc_lo_flag(ocl), .oc_hi_flag(och),
    .therm_flag(th), .below_dis_flag(bd), .ref_code(ref_code), .pgood(pgood),
    .gate_mode(gate_mode), .discharge(discharge), .fault_latched(fault_latched)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural model: 0 idle,1 wait,2 ramp,3 settle,4 run,5 ov latch,6 latch,7 discharge
  int ms = 0, mc = 0, mr = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; mc = 0; mr = 0;
    end else begin
      bit g, sw, armed;
      int nx;
      g  = sa && sb && en;
      sw = (ms >= 2 && ms <= 4);
      nx = ms;
      if (ms == 0) begin
        mr = 0;
        if (g) nx = 1;
      end else if (ms <= 4) begin
        armed = (ms == 2 && mc >= 818) || ms >= 3;
        if (ov) nx = 5;
        else if (th) nx = 6;
        else if (!g) nx = 7;
        else if (sw && och) nx = 6;
        else if (sw && ocl) begin
          if (mr == 4) nx = 6;
          else begin mr++; nx = 1; end
        end
        else if (armed && uv) nx = (ms == 4) ? 6 : 1;
        else if (ms == 1 && mc == 63) nx = 2;
        else if (ms == 2 && mc == 1023) nx = 3;
        else if (ms == 3 && mc == 2) begin nx = 4; mr = 0; end
      end else if (ms == 5) begin
        if (!g) nx = 0;
      end else if (ms == 6) begin
        if (ov) nx = 5;
        else if (!g) nx = 0;
      end else begin
        if (bd) nx = 0;
      end
      if (nx != ms) mc = 0;
      else if (ms >= 1 && ms <= 3) mc++;
      ms = nx;
      #2;
      begin
        int eref, egate;
        bit epg, edis, eflt;
        eref  = (ms == 2) ? mc : ((ms == 3 || ms == 4) ? 1023 : 0);
        epg   = (ms == 4) && !uv && !ov;
        egate = (ms >= 2 && ms <= 4) ? 1 : (ms == 5) ? 2 : ((ms == 0 || ms == 7) && ov) ? 2 : 0;
        edis  = (ms == 6 || ms == 7) && !bd;
        eflt  = (ms == 5 || ms == 6);
        chk(ref_code == eref, "R2 model ref_code", ref_code, eref);
        chk(pgood == epg, "R3 model pgood", pgood, epg);
        chk(gate_mode == egate, "R4 model gate_mode", gate_mode, egate);
        chk(discharge == edis, "R9 model discharge", discharge, edis);
        chk(fault_latched == eflt, "R11 model fault_latched", fault_latched, eflt);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pg(output int n);
    n = 0;
    while (!pgood && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_sw();
    int k = 0;
    while (gate_mode != 2'b01 && k < 200) begin @(negedge clk); k++; end
  endtask

  initial begin
    int n;
    tick(3);
    chk(gate_mode == 0 && pgood == 0 && ref_code == 0, "R1 reset outputs", gate_mode, 0);
    rst_n = 1;
    en = 1; sa = 1; sb = 0;
    tick(100);
    chk(gate_mode == 0, "R1 no start with supply low", gate_mode, 0);
    ov = 1; tick(2);
    chk(gate_mode == 2, "R10 pre-ov bottom gate", gate_mode, 2);
    chk(fault_latched == 0, "R10 pre-ov not latched", fault_latched, 0);
    ov = 0; tick(2);

    // clean start
    sb = 1;
    wait_pg(n);
    chk(n == 1092, "R3 cycles to pgood", n, 1092);
    chk(ref_code == 1023, "R2 ref at full scale", ref_code, 1023);
    uv = 1; #1;
    chk(pgood == 0, "R3 pgood drops on uv", pgood, 0);
    tick(1);
    chk(fault_latched == 1, "R6 uv in regulation latches", fault_latched, 1);
    uv = 0; tick(10);
    chk(fault_latched == 1, "R11 latch holds", fault_latched, 1);
    en = 0; tick(1);
    chk(fault_latched == 0 && gate_mode == 0, "R11 cleared by disable", fault_latched, 0);
    tick(3);

    // uv below and above arm point
    en = 1; tick(1 + 64 + 400);
    uv = 1; tick(3);
    chk(gate_mode == 1 && fault_latched == 0, "R5 uv ignored early in ramp", gate_mode, 1);
    uv = 0;
    while (ref_code < 900) @(negedge clk);
    uv = 1; tick(1); uv = 0;
    chk(gate_mode == 0 && fault_latched == 0 && ref_code == 0, "R6 uv restart gates off", gate_mode, 0);
    wait_pg(n);
    chk(n == 1091, "R6 full restart length", n, 1091);

    // overcurrent low retries during ramp
    en = 0; tick(1); bd = 1; tick(2); bd = 0;
    en = 1;
    for (int i = 1; i <= 5; i++) begin
      wait_sw();
      tick(5);
      ocl = 1; tick(1); ocl = 0;
      if (i < 5) chk(fault_latched == 0 && gate_mode == 0, "R7 retry not latched", fault_latched, 0);
      else       chk(fault_latched == 1, "R7 fifth event latches", fault_latched, 1);
    end
    tick(50);
    chk(fault_latched == 1 && discharge == 1, "R9 discharge after oc latch", discharge, 1);
    en = 0; tick(2);

    // overcurrent high in regulation
    en = 1; wait_pg(n);
    och = 1; tick(1); och = 0;
    chk(fault_latched == 1 && gate_mode == 0, "R8 high oc latches at once", fault_latched, 1);
    chk(discharge == 1, "R9 discharge on", discharge, 1);
    bd = 1; tick(1);
    chk(discharge == 0, "R9 discharge ends below level", discharge, 0);
    bd = 0; en = 0; tick(2);

    // normal disable with pre-ov during discharge
    en = 1; wait_pg(n);
    en = 0; tick(1);
    chk(discharge == 1 && gate_mode == 0 && fault_latched == 0, "R9 disable discharges", discharge, 1);
    ov = 1; tick(1);
    chk(gate_mode == 2 && fault_latched == 0, "R10 pre-ov in discharge", gate_mode, 2);
    ov = 0; bd = 1; tick(2);
    chk(discharge == 0 && gate_mode == 0, "R9 back to idle", discharge, 0);
    bd = 0;

    // overvoltage during ramp
    en = 1; tick(200);
    ov = 1; tick(1);
    chk(fault_latched == 1 && gate_mode == 2 && pgood == 0, "R4 ov latches in ramp", gate_mode, 2);
    ov = 0; tick(5);
    chk(fault_latched == 1 && gate_mode == 2, "R4 ov latch holds", gate_mode, 2);
    en = 0; tick(2);

    // thermal fault
    en = 1; wait_pg(n);
    th = 1; tick(1); th = 0;
    chk(fault_latched == 1 && gate_mode == 0 && discharge == 1, "R12 thermal latch", fault_latched, 1);
    en = 0; tick(5);

    done = 1;
    summary();
    $finish;
  end
endmodule